// File: doc/BRIEF.md
# Zero-Overhead Repeat-Loop Sequencer

This block sits beside the fetch stage of a small DSP-style core. It runs a block of instructions a programmed number of times with no compare or branch instructions in the loop body. Software loads three values: the first address of the loop, an end marker and a repeat count. The block then watches the fetch program counter and the stream of retired instructions. It sends fetch back to the loop's first address as the last loop instruction is fetched, takes one off the count on each pass, and lets fetch run on past the loop after the final pass.

The loop decision is made late in each pass, by an instruction three places ahead of the last one in the body. Call it the detection instruction. The end marker holds the detection instruction's address plus four, not the address of the last instruction. Instructions are `INSTR_BYTES` wide, which is 2 by default, so the last loop instruction sits at end marker + 3·`INSTR_BYTES` − 4. When that instruction retires, the count is checked and decremented, and a redirect is armed for the matching fetch of the last instruction. A count written by software takes effect only once the next instruction retires, so one instruction must lie between the count write and the loop. Loops shorter than four instructions are not supported.

Top module: `hwl_loop_ctrl`

## Requirements
- R1: After reset, `redirect_valid`, `loop_active` and `loop_err` are 0 and `rc_value` is 0.
- R2: With `COUNT_DEFER`=1, a count write leaves `rc_value` unchanged until the next cycle in which `retire_valid` is 1. It then takes `wr_data[CW-1:0]`. A detection match in that same retire cycle is ignored.
- R3: With a count n ≥ 1, the loop body from the start address through the last address (end marker + 3·`INSTR_BYTES` − 4) is fetched exactly n times. `redirect_valid` is raised in the cycle that the last address is fetched on passes 1 to n−1, and fetch then runs on to the next address after the loop.
- R4: Each retirement of the detection instruction (end marker − 4) while the count is nonzero decrements `rc_value` by one. The count is 0 when the loop finishes.
- R5: A count of 0 disables repeating. The body runs once in straight-line order, with no redirect, and `rc_value` stays 0.
- R6: A loop of exactly four instructions is supported. In that case the detection instruction is the first loop instruction.
- R7: When the start address is greater than the last address, `loop_err` is 1, no redirect is issued, the loop never becomes active and `rc_value` is not decremented.
- R8: A write to any loop register clears `loop_active` at the next clock edge. No redirect follows for the aborted loop.
- R9: `redirect_pc` equals the start address whenever `redirect_valid` is 1. `redirect_valid` is 1 only while `loop_active` is 1 and `fetch_pc` equals the last address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_wr_en | input | 1 | Write `wr_data` to the loop start address |
| end_wr_en | input | 1 | Write `wr_data` to the end marker (detection address + 4) |
| count_wr_en | input | 1 | Write `wr_data[CW-1:0]` as the repeat count |
| wr_data | input | AW | Write data for the loop registers |
| fetch_pc | input | AW | Address being fetched this cycle |
| retire_valid | input | 1 | One instruction retires this cycle |
| retire_pc | input | AW | Address of the retiring instruction |
| redirect_valid | output | 1 | Fetch must go to `redirect_pc` next |
| redirect_pc | output | AW | Redirect target (the loop start address) |
| loop_active | output | 1 | A redirect is armed for the current pass |
| loop_err | output | 1 | Start address lies beyond the last address |
| rc_value | output | CW | Current repeat count |

## Verification
The bench builds the block with AW=16, CW=12, INSTR_BYTES=2 and the count write deferred. With these values every address fits in four hex digits, the last address is end marker + 2, and the write-to-count latency can be seen on its own before a program runs. A one-stage model of the pipeline retires each instruction one cycle after its fetch. This keeps the detection-to-last-fetch spacing as tight as it can be, which covers an eight-instruction body and the minimum four-instruction body. Counts of 0, 1 and 4 cover the skip, single-pass and repeat paths. An out-of-order address setting and a mid-pass register write cover the error and abort paths.

// File: rtl/hwl_pkg.sv
package hwl_pkg;
   // Byte distance from the detection instruction to the stored end marker.
   localparam int unsigned HWL_MARK_GAP = 4;
   // Instructions from the detection instruction to the last loop instruction.
   localparam int unsigned HWL_TAIL_INSTRS = 3;

   typedef enum logic [1:0] {
      SEQ_HOLD  = 2'd0,
      SEQ_ARM   = 2'd1,
      SEQ_FIRE  = 2'd2,
      SEQ_ABORT = 2'd3
   } seq_evt_e;
endpackage

// File: rtl/hwl_addr_regs.sv
module hwl_addr_regs #(
   parameter int unsigned AW = 32,
   parameter int unsigned INSTR_BYTES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_wr_en,
   input  logic          end_wr_en,
   input  logic [AW-1:0] wr_data,
   output logic [AW-1:0] start_q,
   output logic [AW-1:0] detect_pc,
   output logic [AW-1:0] last_pc,
   output logic          order_err
);
   import hwl_pkg::*;

   localparam logic [AW-1:0] MARK_GAP = AW'(HWL_MARK_GAP);
   localparam logic [AW-1:0] TAIL_SPAN = AW'(HWL_TAIL_INSTRS * INSTR_BYTES);

   logic [AW-1:0] mark_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
         mark_q  <= '0;
      end else begin
         if (start_wr_en) start_q <= wr_data;
         if (end_wr_en)   mark_q  <= wr_data;
      end
   end

   always_comb begin
      detect_pc = mark_q - MARK_GAP;
      last_pc   = detect_pc + TAIL_SPAN;
      order_err = (start_q > last_pc);
   end
endmodule

// File: rtl/hwl_count.sv
module hwl_count #(
   parameter int unsigned AW = 32,
   parameter int unsigned CW = 12,
   parameter bit          COUNT_DEFER = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          count_wr_en,
   input  logic [AW-1:0] wr_data,
   input  logic          retire_valid,
   input  logic          dec_en,
   output logic [CW-1:0] rc_q,
   output logic          pend_q
);
   generate
      if (COUNT_DEFER) begin : g_defer
         logic [CW-1:0] pend_val_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rc_q       <= '0;
               pend_q     <= 1'b0;
               pend_val_q <= '0;
            end else if (count_wr_en) begin
               pend_val_q <= wr_data[CW-1:0];
               pend_q     <= 1'b1;
            end else if (retire_valid && pend_q) begin
               rc_q   <= pend_val_q;
               pend_q <= 1'b0;
            end else if (dec_en) begin
               rc_q <= rc_q - CW'(1);
            end
         end
      end else begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rc_q <= '0;
            end else if (count_wr_en) begin
               rc_q <= wr_data[CW-1:0];
            end else if (dec_en) begin
               rc_q <= rc_q - CW'(1);
            end
         end
         assign pend_q = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/hwl_seq.sv
module hwl_seq #(
   parameter int unsigned AW = 32,
   parameter int unsigned CW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          any_wr,
   input  logic          retire_valid,
   input  logic [AW-1:0] retire_pc,
   input  logic [AW-1:0] fetch_pc,
   input  logic [AW-1:0] detect_pc,
   input  logic [AW-1:0] last_pc,
   input  logic          order_err,
   input  logic          pend,
   input  logic [CW-1:0] rc,
   output logic          dec_en,
   output logic          armed_q,
   output logic          fire
);
   import hwl_pkg::*;

   logic     det_hit;
   seq_evt_e evt;

   always_comb begin
      det_hit = retire_valid && !pend && (retire_pc == detect_pc);
      dec_en  = det_hit && !any_wr && !order_err && (rc != '0);
      fire    = armed_q && !order_err && (fetch_pc == last_pc);
      if (any_wr)                            evt = SEQ_ABORT;
      else if (fire)                         evt = SEQ_FIRE;
      else if (dec_en && (rc != CW'(1)))     evt = SEQ_ARM;
      else                                   evt = SEQ_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else begin
         case (evt)
            SEQ_ABORT, SEQ_FIRE: armed_q <= 1'b0;
            SEQ_ARM:             armed_q <= 1'b1;
            default:             armed_q <= armed_q;
         endcase
      end
   end
endmodule

// File: rtl/hwl_loop_ctrl.sv
module hwl_loop_ctrl #(
   parameter int unsigned AW = 32,
   parameter int unsigned CW = 12,
   parameter int unsigned INSTR_BYTES = 2,
   parameter bit          COUNT_DEFER = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_wr_en,
   input  logic          end_wr_en,
   input  logic          count_wr_en,
   input  logic [AW-1:0] wr_data,
   input  logic [AW-1:0] fetch_pc,
   input  logic          retire_valid,
   input  logic [AW-1:0] retire_pc,
   output logic          redirect_valid,
   output logic [AW-1:0] redirect_pc,
   output logic          loop_active,
   output logic          loop_err,
   output logic [CW-1:0] rc_value
);
   generate
      if (AW < 8) begin : g_bad_aw
         $error("hwl_loop_ctrl: AW must be at least 8");
      end
      if (CW < 1 || CW > AW) begin : g_bad_cw
         $error("hwl_loop_ctrl: CW must lie in 1..AW");
      end
      if (INSTR_BYTES < 1 || (INSTR_BYTES & (INSTR_BYTES - 1)) != 0) begin : g_bad_ib
         $error("hwl_loop_ctrl: INSTR_BYTES must be a power of two");
      end
   endgenerate

   logic [AW-1:0] start_q;
   logic [AW-1:0] detect_pc;
   logic [AW-1:0] last_pc;
   logic          order_err;
   logic          pend;
   logic          dec_en;
   logic          armed;
   logic          fire;
   logic          any_wr;

   assign any_wr = start_wr_en | end_wr_en | count_wr_en;

   hwl_addr_regs #(.AW(AW), .INSTR_BYTES(INSTR_BYTES)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_wr_en(start_wr_en),
      .end_wr_en  (end_wr_en),
      .wr_data    (wr_data),
      .start_q    (start_q),
      .detect_pc  (detect_pc),
      .last_pc    (last_pc),
      .order_err  (order_err)
   );

   hwl_count #(.AW(AW), .CW(CW), .COUNT_DEFER(COUNT_DEFER)) u_count (
      .clk         (clk),
      .rst_n       (rst_n),
      .count_wr_en (count_wr_en),
      .wr_data     (wr_data),
      .retire_valid(retire_valid),
      .dec_en      (dec_en),
      .rc_q        (rc_value),
      .pend_q      (pend)
   );

   hwl_seq #(.AW(AW), .CW(CW)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .any_wr      (any_wr),
      .retire_valid(retire_valid),
      .retire_pc   (retire_pc),
      .fetch_pc    (fetch_pc),
      .detect_pc   (detect_pc),
      .last_pc     (last_pc),
      .order_err   (order_err),
      .pend        (pend),
      .rc          (rc_value),
      .dec_en      (dec_en),
      .armed_q     (armed),
      .fire        (fire)
   );

   assign redirect_valid = fire;
   assign redirect_pc    = start_q;
   assign loop_active    = armed;
   assign loop_err       = order_err;
endmodule

// File: rtl/hwl_loop_ctrl_chk.sv
module hwl_loop_ctrl_chk #(
   parameter int unsigned AW = 32,
   parameter int unsigned CW = 12
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_wr_en,
   input logic          end_wr_en,
   input logic          count_wr_en,
   input logic          redirect_valid,
   input logic [AW-1:0] redirect_pc,
   input logic [AW-1:0] start_q,
   input logic          loop_active,
   input logic          loop_err,
   input logic [CW-1:0] rc_value
);
   // R9
   redirect_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid |-> (redirect_pc == start_q));

   // R9
   redirect_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid |-> loop_active);

   // R3
   redirect_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid |=> !loop_active);

   // R8
   write_aborts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_wr_en || end_wr_en || count_wr_en) |=> !loop_active);

   // R7
   err_blocks_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_err && !loop_active) |=> !loop_active);

   // R4
   arm_decrements_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(loop_active) |-> (rc_value == $past(rc_value) - CW'(1)));
endmodule

bind hwl_loop_ctrl hwl_loop_ctrl_chk #(.AW(AW), .CW(CW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .start_wr_en   (start_wr_en),
   .end_wr_en     (end_wr_en),
   .count_wr_en   (count_wr_en),
   .redirect_valid(redirect_valid),
   .redirect_pc   (redirect_pc),
   .start_q       (start_q),
   .loop_active   (loop_active),
   .loop_err      (loop_err),
   .rc_value      (rc_value)
);

// File: tb/sim_hwl_loop_ctrl.sv
`timescale 1ns/1ps
module sim_hwl_loop_ctrl;
   localparam int AW = 16;
   localparam int CW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_wr_en = 1'b0;
   logic          end_wr_en = 1'b0;
   logic          count_wr_en = 1'b0;
   logic [AW-1:0] wr_data = '0;
   logic [AW-1:0] fetch_pc = '0;
   logic          retire_valid = 1'b0;
   logic [AW-1:0] retire_pc = '0;
   logic          redirect_valid;
   logic [AW-1:0] redirect_pc;
   logic          loop_active;
   logic          loop_err;
   logic [CW-1:0] rc_value;

   int compared = 0;
   int mismatched = 0;
   logic mon_en = 1'b0;
   string cur_req = "R3";
   logic [AW-1:0] exp_q[$];

   always #2.5 clk = ~clk;

   hwl_loop_ctrl #(.AW(AW), .CW(CW), .INSTR_BYTES(2), .COUNT_DEFER(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n),
      .start_wr_en(start_wr_en), .end_wr_en(end_wr_en), .count_wr_en(count_wr_en),
      .wr_data(wr_data), .fetch_pc(fetch_pc),
      .retire_valid(retire_valid), .retire_pc(retire_pc),
      .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
      .loop_active(loop_active), .loop_err(loop_err), .rc_value(rc_value)
   );

   // Monitor: every monitored fetch is compared with the next expected address.
   always @(posedge clk) begin
      if (mon_en) begin
         compared++;
         if (exp_q.size() == 0) begin
            mismatched++;
            $display("FAIL %s fetch act=%h exp=<none>", cur_req, fetch_pc);
         end else begin
            automatic logic [AW-1:0] e = exp_q.pop_front();
            if (fetch_pc !== e) begin
               mismatched++;
               $display("FAIL %s fetch act=%h exp=%h", cur_req, fetch_pc, e);
            end
         end
      end
   end

   task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic push_range(input logic [AW-1:0] a, input logic [AW-1:0] b);
      for (logic [AW-1:0] p = a; p <= b; p = p + 2) exp_q.push_back(p);
   endtask

   task automatic wr_reg(input int which, input logic [AW-1:0] d);
      @(negedge clk);
      start_wr_en = (which == 0);
      end_wr_en   = (which == 1);
      count_wr_en = (which == 2);
      wr_data     = d;
      @(negedge clk);
      start_wr_en = 1'b0; end_wr_en = 1'b0; count_wr_en = 1'b0;
   endtask

   // Driver: a one-stage pipeline, each fetch retires one cycle later.
   task automatic run(input logic [AW-1:0] first, input logic [AW-1:0] stop,
                      input bit do_abort, input logic [AW-1:0] abort_pc,
                      input logic [AW-1:0] abort_data);
      logic [AW-1:0] npc = first;
      logic [AW-1:0] prev = '0;
      bit pv = 1'b0;
      bit done = 1'b0;
      bit aborted = 1'b0;
      while (!done) begin
         @(negedge clk);
         fetch_pc = npc;
         retire_valid = pv;
         retire_pc = prev;
         start_wr_en = 1'b0;
         if (do_abort && !aborted && npc == abort_pc) begin
            start_wr_en = 1'b1;
            wr_data = abort_data;
            aborted = 1'b1;
         end
         mon_en = 1'b1;
         #1;
         npc = redirect_valid ? redirect_pc : fetch_pc + 2;
         prev = fetch_pc;
         pv = 1'b1;
         if (fetch_pc == stop) done = 1'b1;
      end
      @(negedge clk);
      mon_en = 1'b0;
      start_wr_en = 1'b0;
      fetch_pc = '0;
      retire_valid = 1'b1;
      retire_pc = prev;
      @(negedge clk);
      retire_valid = 1'b0;
      check({cur_req, " leftover"}, AW'(exp_q.size()), '0);
      exp_q.delete();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values
      check("R1 redirect", AW'(redirect_valid), '0);
      check("R1 active", AW'(loop_active), '0);
      check("R1 err", AW'(loop_err), '0);
      check("R1 count", AW'(rc_value), '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: deferred count load
      cur_req = "R2";
      wr_reg(2, 16'd7);
      check("R2 before retire", AW'(rc_value), 16'd0);
      retire_valid = 1'b1; retire_pc = 16'h0010;
      @(negedge clk);
      retire_valid = 1'b0;
      check("R2 after retire", AW'(rc_value), 16'd7);

      // R3 R4: eight-instruction body 0x100..0x10E, detect 0x108, marker 0x10C, count 4
      cur_req = "R3";
      wr_reg(0, 16'h0100);
      wr_reg(1, 16'h010C);
      wr_reg(2, 16'd4);
      check("R7 no err", AW'(loop_err), '0);
      push_range(16'h00F8, 16'h00FE);
      for (int k = 0; k < 4; k++) push_range(16'h0100, 16'h010E);
      push_range(16'h0110, 16'h0114);
      run(16'h00F8, 16'h0114, 1'b0, '0, '0);
      check("R4 count spent", AW'(rc_value), 16'd0);
      check("R3 idle after", AW'(loop_active), '0);

      // R5: count 0 runs once straight
      cur_req = "R5";
      wr_reg(2, 16'd0);
      push_range(16'h00F8, 16'h0114);
      run(16'h00F8, 16'h0114, 1'b0, '0, '0);
      check("R5 count", AW'(rc_value), 16'd0);

      // R3: count 1 runs once
      cur_req = "R3";
      wr_reg(2, 16'd1);
      push_range(16'h00F8, 16'h0114);
      run(16'h00F8, 16'h0114, 1'b0, '0, '0);
      check("R4 count after one pass", AW'(rc_value), 16'd0);

      // R6: four-instruction body 0x200..0x206, detect 0x200, marker 0x204, count 3
      cur_req = "R6";
      wr_reg(0, 16'h0200);
      wr_reg(1, 16'h0204);
      wr_reg(2, 16'd3);
      push_range(16'h01FC, 16'h01FE);
      for (int k = 0; k < 3; k++) push_range(16'h0200, 16'h0206);
      push_range(16'h0208, 16'h020A);
      run(16'h01FC, 16'h020A, 1'b0, '0, '0);
      check("R6 count spent", AW'(rc_value), 16'd0);

      // R7: start 0x300 beyond last 0x2F2 (marker 0x2F0)
      cur_req = "R7";
      wr_reg(0, 16'h0300);
      wr_reg(1, 16'h02F0);
      wr_reg(2, 16'd2);
      check("R7 err flag", AW'(loop_err), 16'd1);
      push_range(16'h02E4, 16'h0304);
      run(16'h02E4, 16'h0304, 1'b0, '0, '0);
      check("R7 count kept", AW'(rc_value), 16'd2);
      check("R7 idle", AW'(loop_active), '0);

      // R8: body 0x400..0x40E, marker 0x40C, count 5; start rewritten at fetch 0x40C of pass 1
      cur_req = "R8";
      wr_reg(0, 16'h0400);
      wr_reg(1, 16'h040C);
      wr_reg(2, 16'd5);
      push_range(16'h03F8, 16'h0414);
      run(16'h03F8, 16'h0414, 1'b1, 16'h040C, 16'h0400);
      check("R8 idle", AW'(loop_active), '0);
      check("R8 count one pass", AW'(rc_value), 16'd4);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule